// File: doc/BRIEF.md
# SPI Serial EEPROM Responder

This block is an SPI target (mode 0) that behaves like a small byte-addressed serial EEPROM. The SPI pins are brought into the system clock domain through synchronizers, and their edges are found there. After chip select falls, the block reads an 8-bit command and, for the read and write commands, a 16-bit byte address, both sent most-significant bit first. A read streams stored bytes back one after another for as long as the master keeps clocking. A write stores each completed byte into a 32-byte page. Writing is allowed only after a separate write-enable frame.

Storage is an internal byte array whose depth is a parameter and must be a power of two. The serial output is split into a data bit and an output enable. The output enable is high only while read data is being returned, so the pad is released at every other time. A pull-up on the line then makes the master read 0xFF during the command and address bytes.

Top module: `spi_eeprom_responder`

## Requirements
- R1: While reset is asserted and afterwards until a read returns data, `spi_miso_oe` is 0. The write enable starts cleared after reset.
- R2: A read is command 0x03 followed by a 16-bit address, MSB first. Only the low log2(DEPTH) address bits select the byte. The first data bit (the byte's MSB) appears after the falling SCLK edge that follows the last address bit. Data bytes are sent MSB first.
- R3: `spi_miso_oe` is 0 during the command and address bytes, and for the whole of any frame whose command is not a read. With a pulled-up line, the master sees 0xFF in those bytes.
- R4: A read continues for as many bytes as the master clocks. The address advances by one after each byte and wraps from DEPTH-1 to 0.
- R5: During the data phase of a read, MOSI has no effect on the data returned.
- R6: After a write-enable frame (command 0x06), a later frame with command 0x02, a 16-bit address and data bytes stores each completed byte at the current address.
- R7: A write command without a prior write-enable frame changes nothing. A write-enable allows only one write command.
- R8: During a write, the address wraps within its 32-byte page: the offset goes from 31 back to 0 and the page bits do not change.
- R9: Raising chip select at any bit aborts the command. It releases the output and restarts bit counting at the next frame. A partly received write byte is discarded.
- R10: `spi_miso` changes only in response to a falling SCLK edge, so it is stable while SCLK is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; it must run much faster than SCLK |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| spi_sclk | input | 1 | SPI serial clock, idle low (mode 0) |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial read data bit |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |

## Verification
The bench first fills the whole array page by page. It then reads the array in one command that runs past the top. A design that failed to wrap, or that stepped the address at the wrong bit, would return shifted data near address DEPTH-1. Writes that start at page offset 30 show whether the page wraps: a wrong design would spill into the next page. Writes without an enable, and a second write after one enable, show whether a design that never clears its enable alters memory. Frames aborted in the middle of the command, the data and a write byte check that the bit counter restarts and no partial byte is stored. The bench also samples MISO twice during each SCLK-high phase, which would catch a design that updates its output on the wrong edge.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRITE = 8'h02;
  localparam logic [7:0] OPC_WREN  = 8'h06;

  localparam int OPC_BITS  = 8;
  localparam int ADDR_BITS = 16;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_RD,
    ST_WR,
    ST_SKIP
  } ee_state_e;
endpackage

// File: rtl/spi_ee_sync.sv
module spi_ee_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic rst_no,
  output logic cs_act_o,
  output logic mosi_o,
  output logic rise_o,
  output logic fall_o
);
  logic [1:0]      rst_q;
  logic [STAGES:0] sclk_q;
  logic [STAGES-1:0] cs_q;
  logic [STAGES-1:0] mosi_q;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_no = rst_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      mosi_q <= '0;
    end else begin
      sclk_q <= {sclk_q[STAGES-1:0], sclk_i};
      cs_q   <= {cs_q[STAGES-2:0], cs_n_i};
      mosi_q <= {mosi_q[STAGES-2:0], mosi_i};
    end
  end

  assign cs_act_o = ~cs_q[STAGES-1];
  assign mosi_o   = mosi_q[STAGES-1];
  assign rise_o   = sclk_q[STAGES-1] & ~sclk_q[STAGES];
  assign fall_o   = ~sclk_q[STAGES-1] & sclk_q[STAGES];
endmodule

// File: rtl/spi_ee_array.sv
module spi_ee_array #(
  parameter int DEPTH  = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] mem_q [DEPTH];

  // storage carries no reset, like the cells it models
  always_ff @(posedge clk) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

  // R6: a store always has a defined target and value
  p_store_known_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    we_i |-> !$isunknown({waddr_i, wdata_i}));
endmodule

// File: rtl/spi_ee_ctrl.sv
module spi_ee_ctrl
  import spi_ee_pkg::*;
#(
  parameter int DEPTH      = 256,
  parameter int PAGE_BYTES = 32,
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int PAGE_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              mosi_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic [7:0]        rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic [7:0]        wdata_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  localparam int CNT_W = $clog2(ADDR_BITS);

  ee_state_e         state_q, state_d;
  logic [CNT_W-1:0]  bitcnt_q, bitcnt_d;
  logic [15:0]       sh_q, sh_d, sh_nx;
  logic              wr_cmd_q, wr_cmd_d;
  logic              wel_q, wel_d;
  logic [ADDR_W-1:0] addr_q, addr_d, page_next;
  logic [7:0]        out_q, out_d;
  logic              oe_q, oe_d;

  // next address inside the current page
  generate
    if (ADDR_W > PAGE_W) begin : g_paged
      assign page_next = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + 1'b1};
    end else begin : g_flat
      assign page_next = addr_q + 1'b1;
    end
  endgenerate

  assign sh_nx = {sh_q[14:0], mosi_i};

  always_comb begin
    state_d  = state_q;
    bitcnt_d = bitcnt_q;
    sh_d     = sh_q;
    wr_cmd_d = wr_cmd_q;
    wel_d    = wel_q;
    addr_d   = addr_q;
    out_d    = out_q;
    oe_d     = oe_q;
    we_o     = 1'b0;
    wdata_o  = sh_nx[7:0];
    if (!cs_act_i) begin
      state_d  = ST_OPC;
      bitcnt_d = '0;
      wr_cmd_d = 1'b0;
      oe_d     = 1'b0;
    end else if (sclk_rise_i) begin
      unique case (state_q)
        ST_OPC: begin
          sh_d     = sh_nx;
          bitcnt_d = bitcnt_q + 1'b1;
          if (bitcnt_q == CNT_W'(OPC_BITS - 1)) begin
            bitcnt_d = '0;
            if (sh_nx[7:0] == OPC_READ) begin
              state_d  = ST_ADDR;
              wr_cmd_d = 1'b0;
            end else if (sh_nx[7:0] == OPC_WRITE && wel_q) begin
              state_d  = ST_ADDR;
              wr_cmd_d = 1'b1;
              wel_d    = 1'b0;
            end else if (sh_nx[7:0] == OPC_WREN) begin
              state_d = ST_SKIP;
              wel_d   = 1'b1;
            end else begin
              state_d = ST_SKIP;
            end
          end
        end
        ST_ADDR: begin
          sh_d     = sh_nx;
          bitcnt_d = bitcnt_q + 1'b1;
          if (bitcnt_q == CNT_W'(ADDR_BITS - 1)) begin
            bitcnt_d = '0;
            addr_d   = sh_nx[ADDR_W-1:0];
            state_d  = wr_cmd_q ? ST_WR : ST_RD;
          end
        end
        ST_RD: begin
          bitcnt_d = bitcnt_q + 1'b1;
          if (bitcnt_q == CNT_W'(7)) begin
            bitcnt_d = '0;
            addr_d   = addr_q + 1'b1;
          end
        end
        ST_WR: begin
          sh_d     = sh_nx;
          bitcnt_d = bitcnt_q + 1'b1;
          if (bitcnt_q == CNT_W'(7)) begin
            bitcnt_d = '0;
            we_o     = 1'b1;
            addr_d   = page_next;
          end
        end
        default: ;
      endcase
    end else if (sclk_fall_i && state_q == ST_RD) begin
      oe_d  = 1'b1;
      out_d = (bitcnt_q == '0) ? rdata_i : {out_q[6:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_OPC;
      bitcnt_q <= '0;
      sh_q     <= '0;
      wr_cmd_q <= 1'b0;
      wel_q    <= 1'b0;
      addr_q   <= '0;
      out_q    <= '0;
      oe_q     <= 1'b0;
    end else begin
      state_q  <= state_d;
      bitcnt_q <= bitcnt_d;
      sh_q     <= sh_d;
      wr_cmd_q <= wr_cmd_d;
      wel_q    <= wel_d;
      addr_q   <= addr_d;
      out_q    <= out_d;
      oe_q     <= oe_d;
    end
  end

  assign addr_o    = addr_q;
  assign miso_o    = out_q[7];
  assign miso_oe_o = oe_q;

  // R9: a deselected device releases the line on the next cycle
  p_release_on_cs_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !cs_act_i |=> !oe_q);
  // R3: the line is driven only while returning read data
  p_drive_only_read_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    oe_q |-> state_q == ST_RD);
  // R10: the data bit moves only on a falling clock edge
  p_miso_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (cs_act_i && !sclk_fall_i) |=> $stable(out_q[7]));
  // R7: a write command without the enable is dropped
  p_write_gated_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (cs_act_i && sclk_rise_i && state_q == ST_OPC && bitcnt_q == CNT_W'(7)
     && sh_nx[7:0] == OPC_WRITE && !wel_q) |=> state_q == ST_SKIP);
  // R4: the read address steps by one after each byte
  p_read_step_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    (cs_act_i && sclk_rise_i && state_q == ST_RD && bitcnt_q == CNT_W'(7))
    |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));
  generate
    if (ADDR_W > PAGE_W) begin : g_page_chk
      // R8: a store never moves the address to another page
      p_page_hold_r8: assert property (@(posedge clk) disable iff (!rst_ni)
        we_o |=> addr_q[ADDR_W-1:PAGE_W] == $past(addr_q[ADDR_W-1:PAGE_W]));
    end
  endgenerate
endmodule

// File: rtl/spi_eeprom_responder.sv
module spi_eeprom_responder #(
  parameter int DEPTH      = 256,
  parameter int PAGE_BYTES = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe
);
  localparam int ADDR_W = $clog2(DEPTH);

  logic              rst_s_n, cs_act, mosi_s, sclk_rise, sclk_fall;
  logic              we;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        wdata, rdata;

  spi_ee_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .cs_n_i(spi_cs_n),
    .mosi_i(spi_mosi), .rst_no(rst_s_n), .cs_act_o(cs_act),
    .mosi_o(mosi_s), .rise_o(sclk_rise), .fall_o(sclk_fall)
  );

  spi_ee_ctrl #(.DEPTH(DEPTH), .PAGE_BYTES(PAGE_BYTES)) i_ctrl (
    .clk(clk), .rst_ni(rst_s_n), .cs_act_i(cs_act), .mosi_i(mosi_s),
    .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall), .rdata_i(rdata),
    .addr_o(addr), .we_o(we), .wdata_o(wdata),
    .miso_o(spi_miso), .miso_oe_o(spi_miso_oe)
  );

  spi_ee_array #(.DEPTH(DEPTH)) i_array (
    .clk(clk), .rst_ni(rst_s_n), .we_i(we), .waddr_i(addr),
    .wdata_i(wdata), .raddr_i(addr), .rdata_o(rdata)
  );
endmodule

// File: tb/test_spi_eeprom_responder.sv
module test_spi_eeprom_responder;
  localparam int DEPTH = 256;
  localparam int HALF  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spi_sclk = 1'b0;
  logic spi_cs_n = 1'b1;
  logic spi_mosi = 1'b0;
  logic spi_miso, spi_miso_oe;

  int total = 0;
  int bad = 0;
  int glitches = 0;
  logic [7:0] model [DEPTH];

  always #4 clk = ~clk;

  spi_eeprom_responder i_spi_eeprom_responder (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
  );

  function automatic logic line();
    return spi_miso_oe ? spi_miso : 1'b1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input int n, input logic [7:0] tx, output logic [7:0] rx);
    logic a, b;
    rx = 8'hFF;
    for (int i = 0; i < n; i++) begin
      spi_mosi = tx[7-i];
      repeat (HALF) @(negedge clk);
      rx = {rx[6:0], line()};
      spi_sclk = 1'b1;
      @(negedge clk);
      a = spi_miso;
      repeat (HALF - 1) @(negedge clk);
      b = spi_miso;
      if (a !== b) glitches++;
      spi_sclk = 1'b0;
    end
  endtask

  task automatic frame_start();
    spi_cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic frame_stop();
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic send_wren();
    logic [7:0] rx;
    frame_start();
    xfer(8, 8'h06, rx);
    frame_stop();
  endtask

  // write n bytes base+3*i from address a; accepted decides the model update
  task automatic write_cmd(input logic [15:0] a, input int n, input int base,
                           input bit accepted);
    logic [7:0] rx;
    frame_start();
    xfer(8, 8'h02, rx);
    xfer(8, a[15:8], rx);
    xfer(8, a[7:0], rx);
    for (int i = 0; i < n; i++) begin
      xfer(8, 8'(base + 3 * i), rx);
      if (accepted)
        model[((a & 16'hFFE0) | ((a + i) & 16'h001F)) % DEPTH] = 8'(base + 3 * i);
    end
    frame_stop();
  endtask

  task automatic read_cmd(input logic [15:0] a, input int n, input string req);
    logic [7:0] rx;
    frame_start();
    xfer(8, 8'h03, rx);
    check("R3 opcode byte floats", rx, 8'hFF);
    xfer(8, a[15:8], rx);
    check("R3 address byte floats", rx, 8'hFF);
    xfer(8, a[7:0], rx);
    for (int i = 0; i < n; i++) begin
      xfer(8, 8'(i * 29 + 7), rx);
      check(req, rx, model[(a + i) % DEPTH]);
    end
    frame_stop();
  endtask

  initial begin
    logic [7:0] rx;
    repeat (5) @(negedge clk);
    check("R1 output released in reset", spi_miso_oe, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 output released after reset", spi_miso_oe, 0);

    // R6: fill the array page by page
    for (int p = 0; p < DEPTH / 32; p++) begin
      send_wren();
      write_cmd(16'(p * 32), 32, p * 17 + 1, 1'b1);
    end
    // R2 R4 R5: stream the whole array and run past the top
    read_cmd(16'h0000, DEPTH + 4, "R4/R5 streamed read with wrap");
    // R2: upper address bits are ignored
    read_cmd(16'hABFD, 5, "R2 high address bits ignored");

    // R7: write without enable, then one enable serves one command only
    write_cmd(16'h0010, 2, 8'h90, 1'b0);
    read_cmd(16'h0010, 2, "R7 write without enable ignored");
    send_wren();
    write_cmd(16'h0012, 1, 8'h44, 1'b1);
    write_cmd(16'h0013, 1, 8'h55, 1'b0);
    read_cmd(16'h0012, 2, "R7 enable consumed by one write");

    // R8: write crosses the page end and wraps to offset 0
    send_wren();
    write_cmd(16'h005E, 4, 8'hA1, 1'b1);
    read_cmd(16'h005E, 2, "R8 page tail written");
    read_cmd(16'h0040, 2, "R8 page head wrapped");
    read_cmd(16'h0060, 1, "R8 next page untouched");

    // R9: abort inside a data byte
    frame_start();
    xfer(8, 8'h03, rx);
    xfer(8, 8'h00, rx);
    xfer(8, 8'h20, rx);
    xfer(3, 8'h00, rx);
    spi_cs_n = 1'b1;
    repeat (HALF) @(negedge clk);
    check("R9 output released on abort", spi_miso_oe, 0);
    repeat (HALF) @(negedge clk);
    // R9: abort inside the command byte
    frame_start();
    xfer(5, 8'h00, rx);
    frame_stop();
    read_cmd(16'h0030, 2, "R9 clean read after aborted command");
    // R9: partial write byte discarded
    send_wren();
    frame_start();
    xfer(8, 8'h02, rx);
    xfer(8, 8'h00, rx);
    xfer(8, 8'h70, rx);
    xfer(8, 8'h99, rx);
    model[8'h70] = 8'h99;
    xfer(4, 8'h00, rx);
    frame_stop();
    read_cmd(16'h0070, 2, "R9 only whole bytes stored");

    // R3: unknown command keeps the line released
    frame_start();
    xfer(8, 8'hA5, rx);
    for (int i = 0; i < 3; i++) begin
      xfer(8, 8'h03, rx);
      check("R3 unknown command floats", rx, 8'hFF);
    end
    frame_stop();

    check("R10 miso stable while sclk high", glitches, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule